// File: doc/BRIEF.md
# Card Slot Access Cycle Generator

This block turns single requests from an on-chip master into complete access cycles on a removable-card slot. The slot is reached through a memory window. Each access has the following parts:
- An address phase, during which the card enables and address are driven ahead of the strobe.
- A strobe phase, which is stretched by programmable wait cycles and by the card's ready line.
- A hold phase, which keeps address and enables stable after the strobe has ended.

The block supports memory and I/O accesses, plus an attribute-space select. The card port width can be set to 8 or 16 bits.

The master raises `req_valid` while `req_ready` is high. In the same cycle it supplies the following:
- direction, space, attribute select, size and address;
- the setup, hold and two wait counts.

The block captures the request and all timing values in that cycle, so later changes on these inputs do not affect the running access. When the access is complete, `rsp_done` pulses high for one cycle and `rsp_rdata` holds the aligned read data.

Top module: `card_cycle_gen`

## Requirements
- R1: During and right after reset, all card-side strobes, both card enables and the register select are high (inactive), `rsp_done` is low and `req_ready` is high.
- R2: The address and the card enables are valid for exactly `cfg_setup` cycles (0 to 15) before the first strobe cycle. No strobe is ever active unless at least one card enable is low.
- R3: With `card_ready` high, the strobe stays low for `cfg_area_wait + min(cfg_card_wait, 50) + 1` cycles. A card wait field above 50 counts as 50.
- R4: `card_ready` is sampled only once the programmed wait has run out. Each cycle in which it is then low adds one more strobe cycle.
- R5: After the strobe ends, the address and the card enables stay valid for exactly `cfg_hold` cycles (0 to 15).
- R6: The strobe used depends on the request:
  - memory read uses `card_oe_n`;
  - memory write uses `card_we_n`;
  - I/O read uses `card_iord_n`;
  - I/O write uses `card_iowr_n`.

  At most one of the four is low in any cycle.
- R7: `card_reg_n` is low, without a break, from the first setup cycle through the last hold cycle when `req_attr` was 1, and it is high at all other times.
- R8: In 16-bit mode (`cfg_bus16`=1), the card enables are chosen as follows:
  - A word access drives both enables low and uses all 16 data bits.
  - A byte access at an even address drives only `card_ce_lo_n` low and uses data bits 7:0.
  - A byte access at an odd address drives only `card_ce_hi_n` low and uses data bits 15:8.
- R9: In 8-bit mode, only `card_ce_lo_n` is ever driven low, and data uses bits 7:0. The full address, bit 0 included, selects the byte, and `req_word` has no effect.
- R10: `rsp_done` is high for exactly one cycle, in the cycle after the last hold cycle, with both card enables high. `rsp_rdata` then holds the read byte zero-extended in bits 7:0, or the full word for a 16-bit word access.
- R11: The request fields and all `cfg_*` values are taken in the accepting cycle. Changing them during the access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | High when idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_attr | input | 1 | 1 = attribute/register space |
| req_word | input | 1 | 1 = 16-bit word access (16-bit mode only) |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| cfg_bus16 | input | 1 | 1 = 16-bit card port, 0 = 8-bit |
| cfg_setup | input | SETUP_W | Setup cycles before the strobe |
| cfg_hold | input | HOLD_W | Hold cycles after the strobe |
| cfg_area_wait | input | AREA_WAIT_W | General window wait count |
| cfg_card_wait | input | CARD_WAIT_W | Card-specific wait count, capped at 50 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Aligned read data |
| card_addr | output | ADDR_W | Address to the card |
| card_ce_lo_n | output | 1 | Low-lane card enable, active low |
| card_ce_hi_n | output | 1 | High-lane card enable, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_reg_n | output | 1 | Attribute/register space select, active low |
| card_wdata | output | 16 | Write data toward the card |
| card_wdata_oe | output | 1 | Write data drive enable |
| card_rdata | input | 16 | Read data from the card |
| card_ready | input | 1 | Card ready; low stretches the strobe |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low for at least one clock before use.
- `req_valid` is raised only while `req_ready` is high.
- `card_ready` is a clean level, sampled only when the strobe's wait count has expired.

The stimulus meets these assumptions as follows:
- It issues each request in an idle cycle and drops `req_valid` after one accepted cycle.
- It drives `card_ready` from the number of strobe cycles already seen.
- It draws the configuration from the full range of every field, including card wait values above 50. It then scrambles all request and configuration inputs once the request has been taken.

// File: rtl/card_cycle_pkg.sv
// Shared types for the card access cycle generator.
// Assumes: one access in flight at a time.
package card_cycle_pkg;

    // Phase of the card access in progress.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Request attributes captured when a request is accepted.
    typedef struct packed {
        logic write;
        logic io;
        logic attr;
        logic word;
        logic bus16;
    } access_t;

endpackage

// File: rtl/card_phase_seq.sv
// Phase sequencer: steps an accepted access through setup, strobe, hold and done.
// Assumes: start is raised only in PH_IDLE. Hold and wait lengths are
// captured at start. card_ready is sampled only once the wait count is spent.
module card_phase_seq
    import card_cycle_pkg::*;
#(
    parameter int SETUP_W = 4,
    parameter int HOLD_W  = 4,
    parameter int WAIT_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SETUP_W-1:0] setup_len,
    input  logic [HOLD_W-1:0]  hold_len,
    input  logic [WAIT_W-1:0]  wait_len,
    input  logic               card_ready,
    output phase_t             phase,
    output logic               capture
);

    localparam int CNT_W = (WAIT_W > SETUP_W) ?
                           ((WAIT_W > HOLD_W) ? WAIT_W : HOLD_W) :
                           ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_t             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [HOLD_W-1:0]  hold_q;
    logic [WAIT_W-1:0]  wait_q;

    // Step through the phases, counting down each phase's remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            wait_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        hold_q <= hold_len;
                        wait_q <= wait_len;
                        if (setup_len != '0) begin
                            phase_q <= PH_SETUP;
                            cnt_q   <= CNT_W'(setup_len) - ONE;
                        end else begin
                            phase_q <= PH_STROBE;
                            cnt_q   <= CNT_W'(wait_len);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= CNT_W'(wait_q);
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                PH_STROBE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - ONE;
                    end else if (card_ready) begin
                        if (hold_q != '0) begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= CNT_W'(hold_q) - ONE;
                        end else begin
                            phase_q <= PH_DONE;
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0) phase_q <= PH_DONE;
                    else             cnt_q   <= cnt_q - ONE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Read data is taken on the edge that ends the strobe.
    always_comb capture = (phase_q == PH_STROBE) && (cnt_q == '0) && card_ready;

    assign phase = phase_q;

    // The strobe cannot end while wait cycles remain.
    assert_wait_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && cnt_q != '0) |=> (phase_q == PH_STROBE));

    // A low ready at the end of the wait extends the strobe.
    assert_ready_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && !card_ready) |=> (phase_q == PH_STROBE));

    // The done phase lasts exactly one cycle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/card_lane_map.sv
// Byte lane steering: picks the card enables from port width, size and
// address bit 0, places write data on the right lanes and aligns read data.
// Assumes: a 16-bit card port made of two lanes, each LANE_W bits wide.
module card_lane_map #(
    parameter int LANE_W = 8
) (
    input  logic                bus16,
    input  logic                word,
    input  logic                addr_lsb,
    input  logic [2*LANE_W-1:0] wdata_in,
    input  logic [2*LANE_W-1:0] card_din,
    output logic                lo_en,
    output logic                hi_en,
    output logic [2*LANE_W-1:0] card_dout,
    output logic [2*LANE_W-1:0] rdata_out
);

    localparam int DATA_W = 2 * LANE_W;

    logic full_word;
    logic odd_byte;

    // Decode the access shape from port width and size.
    always_comb begin
        full_word = bus16 && word;
        odd_byte  = bus16 && !word && addr_lsb;
    end

    // Pick which card enables take part in the access.
    always_comb begin
        lo_en = full_word || !odd_byte;
        hi_en = full_word || odd_byte;
    end

    // Write data: a full word goes straight through; a byte is copied onto both lanes.
    always_comb begin
        if (full_word) card_dout = wdata_in;
        else           card_dout = {wdata_in[LANE_W-1:0], wdata_in[LANE_W-1:0]};
    end

    // Read data: a byte is moved down to the low lane and zero-extended.
    always_comb begin
        if (full_word)     rdata_out = card_din;
        else if (odd_byte) rdata_out = {{(DATA_W-LANE_W){1'b0}}, card_din[DATA_W-1:LANE_W]};
        else               rdata_out = {{(DATA_W-LANE_W){1'b0}}, card_din[LANE_W-1:0]};
    end

endmodule

// File: rtl/card_strobe_dec.sv
// Strobe decode: turns phase and access kind into the active-low strobes
// and the register-space select.
// Assumes: active covers setup, strobe and hold; strobe is the strobe phase only.
module card_strobe_dec (
    input  logic active,
    input  logic strobe,
    input  logic write,
    input  logic io,
    input  logic attr,
    output logic oe_n,
    output logic we_n,
    output logic iord_n,
    output logic iowr_n,
    output logic reg_n
);

    // Pick the strobe pair by space and the strobe within it by direction.
    always_comb begin
        oe_n   = !(strobe && !io && !write);
        we_n   = !(strobe && !io &&  write);
        iord_n = !(strobe &&  io && !write);
        iowr_n = !(strobe &&  io &&  write);
    end

    // Register select covers the whole access window.
    always_comb reg_n = !(active && attr);

endmodule

// File: rtl/card_cycle_gen.sv
// Card slot access cycle generator (top). Accepts one request at a time.
// Captures the request and its timing values, sequences setup, strobe and
// hold, and returns aligned read data with a one-cycle done pulse.
// Assumes: req_valid only matters while req_ready is high.
module card_cycle_gen
    import card_cycle_pkg::*;
#(
    parameter int ADDR_W        = 26,
    parameter int LANE_W        = 8,
    parameter int SETUP_W       = 4,
    parameter int HOLD_W        = 4,
    parameter int AREA_WAIT_W   = 4,
    parameter int CARD_WAIT_W   = 6,
    parameter int CARD_WAIT_MAX = 50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic                   req_io,
    input  logic                   req_attr,
    input  logic                   req_word,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2*LANE_W-1:0]    req_wdata,
    input  logic                   cfg_bus16,
    input  logic [SETUP_W-1:0]     cfg_setup,
    input  logic [HOLD_W-1:0]      cfg_hold,
    input  logic [AREA_WAIT_W-1:0] cfg_area_wait,
    input  logic [CARD_WAIT_W-1:0] cfg_card_wait,
    output logic                   rsp_done,
    output logic [2*LANE_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]      card_addr,
    output logic                   card_ce_lo_n,
    output logic                   card_ce_hi_n,
    output logic                   card_oe_n,
    output logic                   card_we_n,
    output logic                   card_iord_n,
    output logic                   card_iowr_n,
    output logic                   card_reg_n,
    output logic [2*LANE_W-1:0]    card_wdata,
    output logic                   card_wdata_oe,
    input  logic [2*LANE_W-1:0]    card_rdata,
    input  logic                   card_ready
);

    localparam int DATA_W   = 2 * LANE_W;
    localparam int WAIT_MAX = (2 ** AREA_WAIT_W) - 1 + CARD_WAIT_MAX;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [CARD_WAIT_W-1:0] CARD_CAP = CARD_WAIT_W'(CARD_WAIT_MAX);

    phase_t              phase;
    logic                capture;
    logic                start;
    logic                active;
    logic                strobe;
    logic [WAIT_W-1:0]   wait_total;
    logic [CARD_WAIT_W-1:0] card_wait_eff;
    access_t             acc_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                lo_en;
    logic                hi_en;
    logic [DATA_W-1:0]   rdata_aligned;

    // Accept a request only while idle.
    always_comb start = req_valid && (phase == PH_IDLE);

    // Total wait: the window count plus the card count, capped at its maximum.
    always_comb begin
        card_wait_eff = (cfg_card_wait > CARD_CAP) ? CARD_CAP : cfg_card_wait;
        wait_total    = WAIT_W'(cfg_area_wait) + WAIT_W'(card_wait_eff);
    end

    // Capture the request fields when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            acc_q   <= '{write: req_write, io: req_io, attr: req_attr,
                         word: req_word, bus16: cfg_bus16};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Keep the aligned read data taken on the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= rdata_aligned;
    end

    card_phase_seq #(
        .SETUP_W (SETUP_W),
        .HOLD_W  (HOLD_W),
        .WAIT_W  (WAIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .setup_len  (cfg_setup),
        .hold_len   (cfg_hold),
        .wait_len   (wait_total),
        .card_ready (card_ready),
        .phase      (phase),
        .capture    (capture)
    );

    card_lane_map #(
        .LANE_W (LANE_W)
    ) u_lanes (
        .bus16     (acc_q.bus16),
        .word      (acc_q.word),
        .addr_lsb  (addr_q[0]),
        .wdata_in  (wdata_q),
        .card_din  (card_rdata),
        .lo_en     (lo_en),
        .hi_en     (hi_en),
        .card_dout (card_wdata),
        .rdata_out (rdata_aligned)
    );

    // Decode the access window and the strobe phase.
    always_comb begin
        active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe = (phase == PH_STROBE);
    end

    card_strobe_dec u_strb (
        .active (active),
        .strobe (strobe),
        .write  (acc_q.write),
        .io     (acc_q.io),
        .attr   (acc_q.attr),
        .oe_n   (card_oe_n),
        .we_n   (card_we_n),
        .iord_n (card_iord_n),
        .iowr_n (card_iowr_n),
        .reg_n  (card_reg_n)
    );

    // Drive the card enables, address, data enable and the response.
    always_comb begin
        card_ce_lo_n  = !(active && lo_en);
        card_ce_hi_n  = !(active && hi_en);
        card_addr     = addr_q;
        card_wdata_oe = active && acc_q.write;
        req_ready     = (phase == PH_IDLE);
        rsp_done      = (phase == PH_DONE);
        rsp_rdata     = rdata_q;
    end

    // A strobe is always inside an enabled card window.
    assert_strobe_in_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n)
        |-> !(card_ce_lo_n && card_ce_hi_n));

    // At most one of the four strobes is low.
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}) <= 1);

    // The register select does not change inside an access window.
    assert_reg_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(card_reg_n));

    // In 8-bit mode the high-lane enable stays inactive.
    assert_narrow_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q.bus16 |-> card_ce_hi_n);

    // The card enables are released while done is reported.
    assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (card_ce_lo_n && card_ce_hi_n));

endmodule

// File: tb/card_cycle_gen_tb.sv
// Self-checking bench for card_cycle_gen: directed corners plus seeded random accesses.
module card_cycle_gen_tb;

    localparam int ADDR_W = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0, req_io = 1'b0, req_attr = 1'b0, req_word = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_bus16 = 1'b0;
    logic [3:0]  cfg_setup = '0, cfg_hold = '0, cfg_area_wait = '0;
    logic [5:0]  cfg_card_wait = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [ADDR_W-1:0] card_addr;
    logic        card_ce_lo_n, card_ce_hi_n, card_oe_n, card_we_n;
    logic        card_iord_n, card_iowr_n, card_reg_n;
    logic [15:0] card_wdata;
    logic        card_wdata_oe;
    logic [15:0] card_rdata = '0;
    logic        card_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    card_cycle_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_io(req_io), .req_attr(req_attr), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_bus16(cfg_bus16),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_area_wait(cfg_area_wait),
        .cfg_card_wait(cfg_card_wait), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .card_addr(card_addr), .card_ce_lo_n(card_ce_lo_n), .card_ce_hi_n(card_ce_hi_n),
        .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_iord_n(card_iord_n),
        .card_iowr_n(card_iowr_n), .card_reg_n(card_reg_n), .card_wdata(card_wdata),
        .card_wdata_oe(card_wdata_oe), .card_rdata(card_rdata), .card_ready(card_ready)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <= 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected total wait before ready is looked at.
    function automatic int exp_wait(input int aw, input int cw);
        return aw + ((cw > 50) ? 50 : cw);
    endfunction

    // Expected enables {hi,lo}, active high.
    function automatic logic [1:0] exp_ce(input bit bus16, input bit word, input bit a0);
        if (!bus16)    return 2'b01;
        else if (word) return 2'b11;
        else if (a0)   return 2'b10;
        else           return 2'b01;
    endfunction

    function automatic logic [15:0] exp_rdata(input bit bus16, input bit word, input bit a0,
                                              input logic [15:0] din);
        if (bus16 && word)      return din;
        else if (bus16 && a0)   return {8'h00, din[15:8]};
        else                    return {8'h00, din[7:0]};
    endfunction

    // Expected active-low strobes {oe,we,iord,iowr}.
    function automatic logic [3:0] exp_strb(input bit wr, input bit io);
        if (!io && !wr)     return 4'b0111;
        else if (!io && wr) return 4'b1011;
        else if (io && !wr) return 4'b1101;
        else                return 4'b1110;
    endfunction

    task automatic run_txn(input bit wr, input bit io, input bit attr, input bit word,
                           input logic [ADDR_W-1:0] addr, input logic [15:0] wd,
                           input bit bus16, input int su, input int ho, input int aw,
                           input int cw, input int rdy, input logic [15:0] din);
        int  n_setup = 0, n_strobe = 0, n_hold = 0;
        int  bad_kind = 0, bad_reg = 0, bad_ce = 0, bad_addr = 0, bad_wd = 0, bad_order = 0;
        bit  seen_done = 0;
        int  w = exp_wait(aw, cw);
        int  exp_len = ((rdy > w) ? rdy : w) + 1;
        logic [1:0]  ce_e = exp_ce(bus16, word, addr[0]);
        logic [15:0] got = '0;
        @(negedge clk);
        req_write = wr; req_io = io; req_attr = attr; req_word = word;
        req_addr = addr; req_wdata = wd; cfg_bus16 = bus16;
        cfg_setup = 4'(su); cfg_hold = 4'(ho); cfg_area_wait = 4'(aw); cfg_card_wait = 6'(cw);
        card_rdata = din; card_ready = 1'b1; req_valid = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic act, strb;
            @(negedge clk);
            if (i == 0) begin
                // Scramble every request and configuration input (R11).
                req_valid = 1'b0;
                req_write = 1'($urandom); req_io = 1'($urandom); req_attr = 1'($urandom);
                req_word = 1'($urandom); req_addr = ADDR_W'($urandom); req_wdata = 16'($urandom);
                cfg_bus16 = 1'($urandom); cfg_setup = 4'($urandom); cfg_hold = 4'($urandom);
                cfg_area_wait = 4'($urandom); cfg_card_wait = 6'($urandom);
            end
            act  = !card_ce_lo_n || !card_ce_hi_n;
            strb = !card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n;
            if (rsp_done) begin
                seen_done = 1;
                if (act || strb) bad_order++;
                got = rsp_rdata;
                break;
            end
            if (strb) begin
                if (n_hold > 0) bad_order++;
                card_ready = (n_strobe >= rdy);
                n_strobe++;
                if ({card_oe_n, card_we_n, card_iord_n, card_iowr_n} != exp_strb(wr, io)) bad_kind++;
            end else begin
                card_ready = 1'($urandom);
                if (act) begin
                    if (n_strobe == 0) n_setup++;
                    else               n_hold++;
                end
            end
            if (act || strb) begin
                if (card_reg_n != !attr) bad_reg++;
                if ({!card_ce_hi_n, !card_ce_lo_n} != ce_e) bad_ce++;
                if (card_addr != addr) bad_addr++;
                if (card_wdata_oe != wr) bad_wd++;
                if (wr) begin
                    if (ce_e == 2'b11 && card_wdata != wd) bad_wd++;
                    if (ce_e == 2'b01 && card_wdata[7:0] != wd[7:0]) bad_wd++;
                    if (ce_e == 2'b10 && card_wdata[15:8] != wd[7:0]) bad_wd++;
                end
            end else if (card_reg_n != 1'b1) begin
                bad_reg++;
            end
        end
        card_ready = 1'b1;
        check(seen_done, "R10", "done seen", seen_done, 1);
        check(n_setup == su, "R2", "setup cycles", n_setup, su);
        check(n_strobe == exp_len, (rdy > w) ? "R4" : "R3", "strobe cycles", n_strobe, exp_len);
        check(n_hold == ho, "R5", "hold cycles", n_hold, ho);
        check(bad_kind == 0, "R6", "strobe selection errors", bad_kind, 0);
        check(bad_reg == 0, "R7", "register select errors", bad_reg, 0);
        check(bad_ce == 0, bus16 ? "R8" : "R9", "card enable errors", bad_ce, 0);
        check(bad_wd == 0, bus16 ? "R8" : "R9", "write lane errors", bad_wd, 0);
        check(bad_addr == 0 && bad_order == 0, "R11", "address/order errors",
              bad_addr + bad_order, 0);
        if (!wr) check(got == exp_rdata(bus16, word, addr[0], din), "R10", "read data",
                       got, exp_rdata(bus16, word, addr[0], din));
        @(negedge clk);
        check(!rsp_done && req_ready, "R10", "done single cycle, ready again",
              {rsp_done, req_ready}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({card_ce_lo_n, card_ce_hi_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n,
               card_reg_n} == 7'h7F && !rsp_done && req_ready, "R1", "reset outputs",
              {card_ce_lo_n, card_ce_hi_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n,
               card_reg_n, rsp_done, req_ready}, 9'h1FD);
        rst_n = 1'b1;
        @(negedge clk);
        check(card_ce_lo_n && card_ce_hi_n && card_reg_n && !rsp_done && req_ready,
              "R1", "idle after reset", {card_ce_lo_n, card_ce_hi_n, card_reg_n, rsp_done, req_ready},
              5'b11101);

        // Directed corners.
        run_txn(0, 0, 0, 1, 26'h0000010, 16'h0, 1, 0, 0, 0, 0, 0, 16'hA55A);     // R3 minimum
        run_txn(1, 0, 1, 1, 26'h0000020, 16'h1234, 1, 15, 15, 15, 63, 0, 16'h0); // R3 cap at 50
        run_txn(0, 1, 1, 0, 26'h0000031, 16'h0, 1, 2, 3, 1, 2, 9, 16'hBEEF);     // R4 odd byte
        run_txn(1, 1, 0, 0, 26'h0000040, 16'h00C3, 1, 1, 1, 0, 0, 4, 16'h0);     // R8 even byte
        run_txn(0, 0, 0, 1, 26'h0000055, 16'h0, 0, 3, 2, 2, 51, 0, 16'hC0DE);    // R9 word ignored
        run_txn(1, 1, 1, 0, 26'h0000057, 16'h7E81, 0, 0, 5, 3, 0, 6, 16'h0);     // R9 odd addr

        // Seeded random accesses.
        for (int n = 0; n < 220; n++) begin
            int aw = $urandom % 16;
            int cw = $urandom % 64;
            int w  = exp_wait(aw, cw);
            int rdy = ($urandom % 3 == 0) ? (w + 1 + $urandom % 6) : ($urandom % 4);
            run_txn(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    ADDR_W'($urandom), 16'($urandom), 1'($urandom),
                    $urandom % 16, $urandom % 16, aw, cw, rdy, 16'($urandom));
        end
        finish_run();
    end

endmodule